// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's complement operands of a configurable width over several clock cycles. A one-cycle start request, taken only while the block is idle, captures the multiplicand into its own register. It also loads a double-width accumulator whose lower half holds the multiplier and whose upper half is cleared.

On each following clock the block performs one step. It inspects the accumulator's least significant bit together with the bit shifted out on the previous step. Depending on that pair, it adds the multiplicand to the upper half, subtracts it from the upper half, or leaves the upper half unchanged. It then shifts the whole accumulator one place to the right, keeping the sign.

After as many steps as the operand width, the block raises a one-cycle completion pulse. The full signed product then appears on a high-word output and a low-word output, and it stays there until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset the block is idle with busy and done low and both product words zero. A start seen while idle clears the upper accumulator half, places the multiplier in the lower half, clears the previous-bit flag and raises busy on the next cycle.
- R2: Each step decodes the pair (accumulator bit 0, previous bit). Pair 1,0 subtracts the multiplicand from the upper half, pair 0,1 adds it, and pairs 0,0 and 1,1 leave the upper half unchanged.
- R3: The add or subtract touches only the upper half. Subtraction adds the inverted multiplicand plus one. One extra sign bit is kept, so a multiplicand equal to the most negative value still gives the exact product.
- R4: After the add/subtract, every step shifts the whole accumulator right by one place. The new top bit is the sign of the step's result, and the previous-bit flag captures the bit that left position 0.
- R5: Exactly WIDTH steps run per operation. Busy is high for those WIDTH cycles, and done rises on the cycle after the last step, WIDTH+1 cycles after the start was presented.
- R6: Done is high for exactly one cycle. At that point {prod_hi_o, prod_lo_o} equals the signed 2*WIDTH-bit product of the two operands.
- R7: While idle without a new start, both product words hold their value. A start given during the done cycle is accepted.
- R8: A start presented while busy is ignored. The running operation completes with its original operands, and no extra result is produced.
- R9: Extreme operands give exact products, including the most negative value times itself, the most negative value times minus one, zero, and minus one times minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a multiplication (taken only while idle) |
| mcand_i | input | WIDTH | Signed multiplicand, sampled with an accepted start |
| mplier_i | input | WIDTH | Signed multiplier, sampled with an accepted start |
| busy_o | output | 1 | High while steps are running |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | WIDTH | Upper word of the accumulator / product |
| prod_lo_o | output | WIDTH | Lower word of the accumulator / product |

## Verification
The main function is tried with three groups of patterns.

A multiplier of zero keeps every step a no-op. A multiplier of minus one produces a single subtract followed by no-ops. Alternating bit patterns force a subtract and an add on every step. Together these separate a fault in the add path from one in the subtract path.

A stepped trace of 3 times 2 checks the accumulator after the load and after each of the first two steps. This exposes a swapped recode pair or a wrong shift-in bit directly, instead of only through the final product.

Operands at the most negative value show whether the extra adder sign bit is present. Back-to-back operations, with a start given in the done cycle, and a start given mid-run show whether the control accepts and rejects requests at the right times. A sweep of pseudo-random operands covers the remaining bit-pair sequences.

// File: rtl/booth_mul_pkg.sv
`timescale 1ns/1ps
package booth_mul_pkg;

   // Control states of the iteration sequencer
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } booth_state_e;

   // Action selected by the bit-pair recoder
   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_ADD  = 2'b01,
      OP_SUB  = 2'b10
   } booth_op_e;

   // Adder implementation variants
   localparam int ADD_INV_CARRY = 0;  // invert operand, carry-in of one
   localparam int ADD_NEG_MUX   = 1;  // precomputed negation, operand mux

endpackage

// File: rtl/booth_ctrl.sv
`timescale 1ns/1ps
module booth_ctrl
   import booth_mul_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);

   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

   booth_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             last_step;

   assign last_step = (cnt_q == LAST_STEP);
   assign load_o    = start_i && (state_q == ST_IDLE);
   assign step_o    = (state_q == ST_RUN);
   assign busy_o    = step_o;
   assign done_o    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               if (last_step) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R5: steps advance one per clock until the last one
   assert_step_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !last_step) |=> (step_o && cnt_q == $past(cnt_q) + 1'b1));

   // R5: completion only follows a running step
   assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(step_o));

   // R6: completion is a single-cycle pulse
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: a start while running does not reset the step count
   assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && start_i && !last_step) |=> (cnt_q != '0));

endmodule

// File: rtl/booth_recode.sv
`timescale 1ns/1ps
module booth_recode
   import booth_mul_pkg::*;
(
   input  logic      cur_bit_i,
   input  logic      prev_bit_i,
   output booth_op_e op_o
);

   always_comb begin
      unique case ({cur_bit_i, prev_bit_i})
         2'b10:   op_o = OP_SUB;
         2'b01:   op_o = OP_ADD;
         default: op_o = OP_NONE;
      endcase
   end

endmodule

// File: rtl/booth_addsub.sv
`timescale 1ns/1ps
module booth_addsub
   import booth_mul_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int ADD_IMPL = ADD_INV_CARRY
) (
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  booth_op_e        op_i,
   output logic [WIDTH:0]   sum_o
);

   localparam int EXT_W = WIDTH + 1;

   logic [EXT_W-1:0] acc_ext;
   logic [EXT_W-1:0] mc_ext;

   assign acc_ext = {acc_i[WIDTH-1], acc_i};
   assign mc_ext  = {mcand_i[WIDTH-1], mcand_i};

   generate
      if (ADD_IMPL == ADD_INV_CARRY) begin : g_inv_carry
         logic             do_sub;
         logic [EXT_W-1:0] operand;
         assign do_sub  = (op_i == OP_SUB);
         assign operand = (op_i == OP_NONE) ? '0 : mc_ext;
         assign sum_o   = acc_ext + (operand ^ {EXT_W{do_sub}}) + EXT_W'(do_sub);
      end else begin : g_neg_mux
         logic [EXT_W-1:0] neg_mc;
         logic [EXT_W-1:0] operand;
         assign neg_mc = ~mc_ext + EXT_W'(1);
         always_comb begin
            unique case (op_i)
               OP_ADD:  operand = mc_ext;
               OP_SUB:  operand = neg_mc;
               default: operand = '0;
            endcase
         end
         assign sum_o = acc_ext + operand;
      end
   endgenerate

endmodule

// File: rtl/booth_datapath.sv
`timescale 1ns/1ps
module booth_datapath
   import booth_mul_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int ADD_IMPL = ADD_INV_CARRY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   output logic [WIDTH-1:0] prod_hi_o,
   output logic [WIDTH-1:0] prod_lo_o
);

   logic [WIDTH-1:0] hi_q;
   logic [WIDTH-1:0] lo_q;
   logic [WIDTH-1:0] mcand_q;
   logic             prev_q;
   booth_op_e        op;
   logic [WIDTH:0]   sum;

   booth_recode u_recode (
      .cur_bit_i  (lo_q[0]),
      .prev_bit_i (prev_q),
      .op_o       (op)
   );

   booth_addsub #(
      .WIDTH    (WIDTH),
      .ADD_IMPL (ADD_IMPL)
   ) u_addsub (
      .acc_i   (hi_q),
      .mcand_i (mcand_q),
      .op_i    (op),
      .sum_o   (sum)
   );

   // Extended sum supplies the true sign for the arithmetic shift
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_q    <= '0;
         mcand_q <= '0;
         prev_q  <= 1'b0;
      end else if (load_i) begin
         hi_q    <= '0;
         lo_q    <= mplier_i;
         mcand_q <= mcand_i;
         prev_q  <= 1'b0;
      end else if (step_i) begin
         hi_q   <= sum[WIDTH:1];
         lo_q   <= {sum[0], lo_q[WIDTH-1:1]};
         prev_q <= lo_q[0];
      end
   end

   assign prod_hi_o = hi_q;
   assign prod_lo_o = lo_q;

   // R1: load clears the upper half and the flag, places the multiplier low
   assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (hi_q == '0 && lo_q == $past(mplier_i) && !prev_q
                  && mcand_q == $past(mcand_i)));

   // R4: lower half shifts by one, flag takes the departing bit
   assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (lo_q[WIDTH-2:0] == $past(lo_q[WIDTH-1:1]) && prev_q == $past(lo_q[0])));

   // R2: an equal bit pair only shifts the upper half with sign fill
   assert_noop_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && (lo_q[0] == prev_q)) |=>
         (hi_q == $past({hi_q[WIDTH-1], hi_q[WIDTH-1:1]}) && lo_q[WIDTH-1] == $past(hi_q[0])));

   // R7: accumulator holds when neither loading nor stepping
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_i) |=> ($stable(hi_q) && $stable(lo_q)));

   // R8: the multiplicand cannot change during a run
   assert_mcand_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> $stable(mcand_q));

endmodule

// File: rtl/booth_seq_mul.sv
`timescale 1ns/1ps
module booth_seq_mul
   import booth_mul_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int ADD_IMPL = ADD_INV_CARRY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] prod_hi_o,
   output logic [WIDTH-1:0] prod_lo_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("booth_seq_mul: WIDTH must be at least 2");
      end
      if (ADD_IMPL != ADD_INV_CARRY && ADD_IMPL != ADD_NEG_MUX) begin : g_bad_impl
         $error("booth_seq_mul: ADD_IMPL selects an unknown adder variant");
      end
   endgenerate

   logic load;
   logic step;

   booth_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   booth_datapath #(
      .WIDTH    (WIDTH),
      .ADD_IMPL (ADD_IMPL)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .step_i    (step),
      .mcand_i   (mcand_i),
      .mplier_i  (mplier_i),
      .prod_hi_o (prod_hi_o),
      .prod_lo_o (prod_lo_o)
   );

   // R7: outputs hold through the done cycle into idle
   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> ($stable(prod_hi_o) && $stable(prod_lo_o)));

endmodule

// File: tb/sim_booth_seq_mul.sv
`timescale 1ns/1ps
module sim_booth_seq_mul;

   localparam int W = 8;

   typedef struct {
      logic [2*W-1:0] prod;
      int             cyc;
      string          tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] mcand = '0;
   logic [W-1:0] mplier = '0;
   logic         busy, done;
   logic [W-1:0] hi, lo;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   logic prev_done = 1'b0;
   exp_t scb[$];

   always #2.5 clk = ~clk;

   booth_seq_mul #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .mcand_i(mcand), .mplier_i(mplier),
      .busy_o(busy), .done_o(done), .prod_hi_o(hi), .prod_lo_o(lo)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b));
      return p[2*W-1:0];
   endfunction

   // Driver: call right after a falling edge; returns at the next falling edge
   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      exp_t e;
      #1;
      mcand = a; mplier = b; start = 1'b1;
      e.prod = ref_mul(a, b); e.cyc = cyc; e.tag = tag;
      scb.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic mul(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      @(negedge clk);
      issue(a, b, tag);
      wait_done();
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Monitor: pops expected products as completion pulses appear
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (done) begin
            if (prev_done) chk("R6 pulse width", 64'(1), 64'(0));
            if (scb.size() == 0) begin
               chk("R8 unexpected result", 64'(1), 64'(0));
            end else begin
               exp_t e;
               e = scb.pop_front();
               chk({"R6 product ", e.tag}, 64'({hi, lo}), 64'(e.prod));
               chk({"R5 latency ", e.tag}, 64'(cyc - e.cyc), 64'(W + 1));
            end
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 reset busy", 64'(busy), 64'(0));
      chk("R1 reset done", 64'(done), 64'(0));
      chk("R1 reset product", 64'({hi, lo}), 64'(0));
      rst_n = 1'b1;

      // R1/R2/R4: stepped trace of 3 * 2
      @(negedge clk);
      issue(8'd3, 8'd2, "3*2");
      chk("R1 busy after load", 64'(busy), 64'(1));
      chk("R1 loaded upper", 64'(hi), 64'(0));
      chk("R1 loaded lower", 64'(lo), 64'(8'd2));
      @(negedge clk);   // pair 0,0: shift only
      chk("R4 step1 upper", 64'(hi), 64'(8'h00));
      chk("R4 step1 lower", 64'(lo), 64'(8'h01));
      @(negedge clk);   // pair 1,0: subtract 3 then shift
      chk("R2 step2 upper", 64'(hi), 64'(8'hFE));
      chk("R4 step2 lower", 64'(lo), 64'(8'h80));
      wait_done();

      // R5: busy width over a full run
      begin
         int busy_cnt = 0;
         @(negedge clk);
         issue(8'd5, 8'd7, "5*7");
         while (!done) begin
            if (busy) busy_cnt++;
            @(negedge clk);
         end
         chk("R5 busy cycles", 64'(busy_cnt), 64'(W));
      end

      // R2: distinct recode patterns
      mul(8'd2, 8'hFD, "2*-3");
      mul(8'd45, 8'h00, "x*0 all no-op");
      mul(8'd45, 8'hFF, "x*-1 one subtract");
      mul(8'h39, 8'h55, "alternating 01");
      mul(8'hC7, 8'hAA, "alternating 10");

      // R3/R9: extreme operands
      mul(8'h80, 8'h80, "min*min");
      mul(8'h80, 8'hFF, "min*-1");
      mul(8'h80, 8'h01, "min*1");
      mul(8'h7F, 8'h80, "max*min");
      mul(8'hFF, 8'hFF, "-1*-1");
      mul(8'h00, 8'h80, "0*min");

      // R7: result holds after done, start in done cycle accepted
      @(negedge clk);
      issue(8'd11, 8'hF3, "11*-13");
      wait_done();
      repeat (3) @(negedge clk);
      chk("R7 hold product", 64'({hi, lo}), 64'(ref_mul(8'd11, 8'hF3)));
      chk("R7 done stays low", 64'(done), 64'(0));
      issue(8'd9, 8'd9, "first back-to-back");
      wait_done();
      issue(8'hF0, 8'd3, "start in done cycle");
      chk("R7 start in done cycle accepted", 64'(busy), 64'(1));
      wait_done();

      // R8: start while busy is ignored
      @(negedge clk);
      issue(8'd6, 8'd7, "6*7 with stray start");
      @(negedge clk);
      #1; mcand = 8'h81; mplier = 8'h7E; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 still busy", 64'(busy), 64'(1));
      wait_done();
      repeat (W + 3) @(negedge clk);
      chk("R8 no extra result", 64'(scb.size()), 64'(0));

      // R9: pseudo-random sweep
      for (int i = 0; i < 40; i++) begin
         mul(W'($urandom), W'($urandom), "random");
      end

      @(negedge clk);
      chk("R6 all results seen", 64'(scb.size()), 64'(0));
      finish_run();
   end

endmodule